// File: doc/BRIEF.md
# Performance-Monitor Counter Update Controller

This block keeps two running tallies for a bit-error-rate tester: one counts the bits the pattern checker has examined, and the other counts the mismatches it has flagged. When an update is requested, it copies both tallies into holding registers that stay stable until the next update. In the same clock it restarts the running tallies, so that each snapshot covers exactly one measurement interval. Both tallies saturate at their maximum value and do not wrap.

The update request comes from one of two sources, and a mode input chooses which. In local mode a software-owned request bit starts an update on its rising edge. In external mode a strobe from elsewhere in the chip does the same. Edge detection runs on the selected source, not on either raw input. As a result, changing the mode while the newly chosen source is already high also counts as a request. A done flag rises together with the new snapshot and falls once the selected request has gone low again. Software raises the bit, waits for the flag, and then drops the bit.

Top module: `pm_snap_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low), bit_hold and err_hold read 0 and upd_done reads 0.
- R2: With src_sel = 0 (local mode), loc_req sampled high at a clock edge after being sampled low at the previous edge starts an update at that edge. From that edge on, the holding outputs show the new snapshot and upd_done reads 1.
- R3: A request that stays high starts no further update. The holding outputs change only at an update edge.
- R4: An update loads bit_hold and err_hold with the number of bit_en and err_pulse pulses sampled at edges after the previous update edge and before this one.
- R5: A pulse sampled at the update edge itself is counted into the new interval, so the running tally restarts at 1 instead of 0.
- R6: With src_sel = 1 (external mode), rising edges of ext_upd start updates, and loc_req has no effect on any output.
- R7: When src_sel changes so that the newly selected source is high while the previously selected one was low, an update starts at that edge.
- R8: upd_done falls at the first edge where the selected source is sampled low, unless that edge starts an update.
- R9: upd_done stays high while the selected source stays high.
- R10: The bit tally holds at 2^BIT_W-1 and the error tally holds at 2^ERR_W-1 instead of wrapping. The defaults are BIT_W = 32 and ERR_W = 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 1 | Request source: 0 = local bit, 1 = external strobe |
| loc_req | input | 1 | Local update request bit |
| ext_upd | input | 1 | External update strobe, synchronous to clk |
| bit_en | input | 1 | One pulse per bit examined by the checker |
| err_pulse | input | 1 | One pulse per bit error flagged by the checker |
| bit_hold | output | BIT_W | Bit tally from the last completed interval |
| err_hold | output | ERR_W | Error tally from the last completed interval |
| upd_done | output | 1 | Update-complete flag |

## Verification
The assertions assume that every input is synchronous to clk and sampled only at rising edges. In particular, the external strobe is assumed to be synchronized before it reaches the block, so each level seen at an edge is a valid request level. The stimulus changes inputs only at falling edges and holds each request level for at least one full cycle. It also runs the bit and error pulses independently, because the block places no ordering between them. To keep saturation within reach, the bench narrows both tallies.

// File: rtl/pm_snap_pkg.sv
package pm_snap_pkg;
  typedef enum logic {SRC_LOCAL = 1'b0, SRC_EXT = 1'b1} src_t;

  function automatic logic pick_source(input src_t s, input logic loc, input logic ext);
    return (s == SRC_EXT) ? ext : loc;
  endfunction
endpackage

// File: rtl/pm_snap_trig.sv
module pm_snap_trig
  import pm_snap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic loc_req,
  input  logic ext_upd,
  output logic sel_req,
  output logic upd_fire,
  output logic upd_done
);
  logic req_q;

  assign sel_req  = pick_source(src_t'(src_sel), loc_req, ext_upd);
  assign upd_fire = sel_req & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      upd_done <= 1'b0;
    end else begin
      req_q <= sel_req;
      if (upd_fire)      upd_done <= 1'b1;
      else if (!sel_req) upd_done <= 1'b0;
    end
  end

  AST_DONE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> upd_done); // R2
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_req) |=> !upd_done); // R8
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && sel_req) |=> upd_done); // R9
endmodule

// File: rtl/pm_sat_cnt.sv
module pm_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  function automatic logic [W-1:0] sat_step(input logic [W-1:0] cur, input logic step);
    if (!step || cur == MAXV) return cur;
    return cur + 1'b1;
  endfunction

  function automatic logic [W-1:0] restart(input logic step);
    return {{(W-1){1'b0}}, step};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= restart(inc);
    else          cnt <= sat_step(cnt, inc);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !clr) |=> cnt == MAXV); // R10
  AST_RESTART_KEEPS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == {{(W-1){1'b0}}, $past(inc)}); // R5
endmodule

// File: rtl/pm_snap_ctrl.sv
module pm_snap_ctrl #(
  parameter int BIT_W = 32,
  parameter int ERR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_sel,
  input  logic             loc_req,
  input  logic             ext_upd,
  input  logic             bit_en,
  input  logic             err_pulse,
  output logic [BIT_W-1:0] bit_hold,
  output logic [ERR_W-1:0] err_hold,
  output logic             upd_done
);
  logic             sel_req;
  logic             upd_fire;
  logic [BIT_W-1:0] bit_cnt;
  logic [ERR_W-1:0] err_cnt;

  pm_snap_trig u_trig (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .loc_req(loc_req),
    .ext_upd(ext_upd), .sel_req(sel_req), .upd_fire(upd_fire), .upd_done(upd_done)
  );

  pm_sat_cnt #(.W(BIT_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .inc(bit_en), .clr(upd_fire), .cnt(bit_cnt)
  );

  pm_sat_cnt #(.W(ERR_W)) u_errs (
    .clk(clk), .rst_n(rst_n), .inc(err_pulse), .clr(upd_fire), .cnt(err_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_hold <= '0;
      err_hold <= '0;
    end else if (upd_fire) begin
      bit_hold <= bit_cnt;
      err_hold <= err_cnt;
    end
  end

  AST_SNAPSHOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> (bit_hold == $past(bit_cnt)) && (err_hold == $past(err_cnt))); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> $stable(bit_hold) && $stable(err_hold)); // R3
  AST_LOCAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && ext_upd == $past(ext_upd) && $past(src_sel)) |-> !upd_fire); // R6
endmodule

// File: tb/pm_snap_ctrl_tb_top.sv
module pm_snap_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 10;
  localparam int EW = 6;
  localparam logic [BW-1:0] BMAX = {BW{1'b1}};
  localparam logic [EW-1:0] EMAX = {EW{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic src_sel = 0, loc_req = 0, ext_upd = 0, bit_en = 0, err_pulse = 0;
  logic [BW-1:0] bit_hold;
  logic [EW-1:0] err_hold;
  logic upd_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_snap_ctrl #(.BIT_W(BW), .ERR_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .loc_req(loc_req),
    .ext_upd(ext_upd), .bit_en(bit_en), .err_pulse(err_pulse),
    .bit_hold(bit_hold), .err_hold(err_hold), .upd_done(upd_done)
  );

  typedef struct {
    logic [BW-1:0] b;
    logic [EW-1:0] e;
    logic          d;
    string         tag;
  } exp_t;

  exp_t q[$];
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  logic [BW-1:0] m_bc = 0, m_bh = 0;
  logic [EW-1:0] m_ec = 0, m_eh = 0;
  logic m_done = 0, m_prev = 0;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic step(input logic s, input logic l, input logic x,
                      input logic b, input logic e, input string tag);
    logic sreq, fire;
    exp_t it;
    @(negedge clk);
    src_sel = s; loc_req = l; ext_upd = x; bit_en = b; err_pulse = e;
    @(posedge clk);
    sreq = s ? x : l;
    fire = sreq && !m_prev;
    if (fire) begin
      m_bh = m_bc; m_eh = m_ec;
      m_bc = {{(BW-1){1'b0}}, b};
      m_ec = {{(EW-1){1'b0}}, e};
      m_done = 1;
    end else begin
      if (b && m_bc != BMAX) m_bc = m_bc + 1'b1;
      if (e && m_ec != EMAX) m_ec = m_ec + 1'b1;
      if (!sreq) m_done = 0;
    end
    m_prev = sreq;
    it.b = m_bh; it.e = m_eh; it.d = m_done; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        n_vec++;
        if (bit_hold !== it.b || err_hold !== it.e || upd_done !== it.d) begin
          n_bad++;
          $display("FAIL %s: got bits=%0d errs=%0d done=%0b, expected bits=%0d errs=%0d done=%0b",
                   it.tag, bit_hold, err_hold, upd_done, it.b, it.e, it.d);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #2;
    n_vec++;
    if (bit_hold !== '0 || err_hold !== '0 || upd_done !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got bits=%0d errs=%0d done=%0b, expected 0 0 0",
               bit_hold, err_hold, upd_done);
    end
    @(negedge clk); rst_n = 1'b1;

    // Local mode, mixed pulse pattern, then a request (R2, R4, R9, R3, R8)
    for (int i = 0; i < 20; i++) step(0, 0, 0, (i % 3) != 0, (i % 7) == 0, "R4");
    step(0, 1, 0, 0, 0, "R2");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 1, i[0], "R9");
    step(0, 0, 0, 1, 0, "R8");
    step(0, 0, 0, 0, 0, "R3");
    // Request edge with a pulse at the same edge (R5)
    step(0, 1, 0, 1, 1, "R5");
    step(0, 0, 0, 0, 0, "R8");
    step(0, 1, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, "R3");

    // External mode: local bit toggles are ignored (R6)
    step(1, 0, 0, 1, 0, "R6");
    for (int i = 0; i < 8; i++) step(1, i[0], 0, 1, i[1], "R6");
    step(1, 0, 1, 1, 1, "R6");
    step(1, 1, 1, 0, 0, "R9");
    step(1, 0, 0, 1, 0, "R8");
    step(1, 1, 0, 1, 0, "R6");

    // Mode switch into a high source (R7)
    step(0, 0, 1, 1, 0, "R7");
    step(1, 0, 1, 1, 1, "R7");
    step(1, 1, 1, 0, 0, "R9");
    step(0, 1, 0, 1, 0, "R7");
    step(0, 1, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, "R8");

    // Saturation (R10)
    for (int i = 0; i < 1100; i++) step(0, 0, 0, 1, 1, "R10");
    step(0, 1, 0, 1, 0, "R10");
    step(0, 0, 0, 0, 0, "R10");
    step(0, 1, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, "R8");

    repeat (3) @(posedge clk);
    #3;
    summary();
  end
endmodule